// File: doc/BRIEF.md
# Portable-System Power State Controller

This block decides how awake a battery-powered system is. It moves through three operating states: ON, DOZE and SLEEP. A free-running prescaler divides the core clock into a slow tick. Two inactivity timers count that tick: one takes the system from ON to DOZE, and a second, started on entry to DOZE, takes it on to SLEEP. A snooper on the I/O address bus watches for accesses to the display, fixed-disk, diskette, serial, keyboard and printer-port address windows. It also watches one fixed eight-address window and two software-placed windows, each either eight or sixteen addresses wide. Any watched access restarts both timers and pulls DOZE back to ON. SLEEP ignores bus activity and is left only on a push-button pulse or a real-time-clock alarm.

A third, independent timer switches the display backlight off after its own idle period. While wall power is present, the state is pinned to ON, the timers are held clear and the backlight stays lit. Three output pins present the state, and software chooses the level of each pin in each state. A two-bit code reports the more severe of two battery alarms. Software programs everything through a flat write port, and reads it back through a combinational read port.

Top module: `pwr_state_ctl`

## Requirements
- R1: After reset the state is ON, the pins read 3'b001 (per-state levels reset to ON=001, DOZE=010, SLEEP=100), the backlight is on, all timeouts read 0 and every monitor source is enabled.
- R2: In ON, with no watched activity or wake event, the state enters DOZE on the doze-timeout-th slow tick after the last restart. A doze timeout of 0 keeps the state in ON indefinitely.
- R3: In DOZE, the state enters SLEEP on the sleep-timeout-th slow tick after DOZE was entered. A sleep timeout of 0 keeps DOZE indefinitely. ON never goes directly to SLEEP.
- R4: A watched access while in ON restarts the doze timer. A watched access while in DOZE returns the state to ON within two clocks.
- R5: In SLEEP, I/O accesses have no effect. A high `btn_wake` or `rtc_alarm` in SLEEP or DOZE returns the state to ON.
- R6: The built-in device windows are: display 0x3B0–0x3DF, fixed disk 0x1F0–0x1F7, diskette 0x3F0–0x3F7, serial 0x2F8–0x2FF and 0x3F8–0x3FF, keyboard 0x060 and 0x064, printer 0x378–0x37F. Enable register (address 7) bits 0..5 gate these six sources in that order. A disabled source causes no wake.
- R7: Window A (base at address 4, enable bit 7) and window B (base at address 5, enable bit 8) match when the address equals the base with its low 3 bits ignored. When the matching width bit in address 6 is set (bit 0 for A, bit 1 for B), the low 4 bits are ignored instead.
- R8: The fixed window covers FIXED_BASE to FIXED_BASE+7 (0x170–0x177 by default) and is gated by enable bit 6.
- R9: While `ac_present` is high, the state is ON within one clock, the timers do not advance and the backlight is on.
- R10: `state_pins` shows the 3-bit field of the level register (address 3) for the current state: bits 2:0 for ON, 5:3 for DOZE, 8:6 for SLEEP.
- R11: The backlight turns on one clock after a watched access or wake event. It turns off after backlight-timeout (address 2) idle slow ticks. A timeout of 0 never turns it off.
- R12: `batt_warn` is 2'b10 when `bat_crit` is high, 2'b01 when only `bat_low` is high, and 2'b00 otherwise.
- R13: Timeout registers (addresses 0, 1, 2) keep TMR_W bits and read back zero-extended. Address 8 reads the state code (0 ON, 1 DOZE, 2 SLEEP) in bits 1:0 and the backlight in bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for write and read |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr` |
| io_valid | input | 1 | An I/O cycle is on the bus this clock |
| io_addr | input | AW | I/O address of that cycle |
| btn_wake | input | 1 | Push-button wake request |
| rtc_alarm | input | 1 | Real-time-clock alarm wake request |
| ac_present | input | 1 | Wall power present |
| bat_low | input | 1 | Battery low alarm |
| bat_crit | input | 1 | Battery critical alarm |
| state_pins | output | 3 | Per-state programmable indicator pins |
| backlight_on | output | 1 | Backlight enable |
| batt_warn | output | 2 | Battery warning code |

## Verification
The bench measures how long the ladder takes to go from an access to DOZE and from DOZE to SLEEP. A design with an off-by-one tick count, or one that never restarts a timer, falls outside the accepted window. It probes the edges of each address window: 0x309 against an eight-wide window at 0x300 and 0x178 against the fixed window. A mask built at the wrong width would wake on these addresses when it should not. It also drives bus accesses in SLEEP, on a disabled source and with wall power present. A design that lets such an access through, or lets a timer run under wall power, produces a pin change that the scoreboard never queued.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;

   typedef enum logic [1:0] {
      PS_ON    = 2'd0,
      PS_DOZE  = 2'd1,
      PS_SLEEP = 2'd2
   } pstate_e;

   // two software-placed windows; register map below assumes this count
   localparam int NGRP = 2;
   // six device windows, one fixed window, then the software windows
   localparam int NSRC = 7 + NGRP;

   localparam int SRC_FIXED = 6;
   localparam int SRC_GRP0  = 7;

   localparam logic [3:0] RA_DOZE_TO  = 4'd0;
   localparam logic [3:0] RA_SLEEP_TO = 4'd1;
   localparam logic [3:0] RA_BL_TO    = 4'd2;
   localparam logic [3:0] RA_PIN_LVL  = 4'd3;
   localparam logic [3:0] RA_GRP_A    = 4'd4;
   localparam logic [3:0] RA_GRP_B    = 4'd5;
   localparam logic [3:0] RA_GRP_WIDE = 4'd6;
   localparam logic [3:0] RA_MON_EN   = 4'd7;
   localparam logic [3:0] RA_STATUS   = 4'd8;

   localparam logic [8:0] PIN_LVL_RST = 9'b100_010_001;

endpackage

// File: rtl/pwr_tick_gen.sv
module pwr_tick_gen #(
   parameter int DIV = 1024
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);

   if (DIV < 1) begin : g_bad_div
      $error("pwr_tick_gen: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_pass
      assign tick = 1'b1;
   end else begin : g_div
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (cnt_q == LAST) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end

      assign tick = (cnt_q == LAST);
   end

endmodule

// File: rtl/pwr_idle_timer.sv
module pwr_idle_timer #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         run,
   input  logic         clr,
   input  logic [W-1:0] limit,
   output logic         expired
);

   if (W < 2) begin : g_bad_w
      $error("pwr_idle_timer: W must be at least 2");
   end

   logic [W-1:0] cnt_q;
   logic         exp_q;
   logic         armed;

   assign armed = run && tick && (limit != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         exp_q <= 1'b0;
      end else if (clr) begin
         cnt_q <= '0;
         exp_q <= 1'b0;
      end else if (armed) begin
         // >= so a limit lowered below the running count still fires
         if (cnt_q >= limit - 1'b1) begin
            cnt_q <= '0;
            exp_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
            exp_q <= 1'b0;
         end
      end else begin
         exp_q <= 1'b0;
      end
   end

   assign expired = exp_q;

endmodule

// File: rtl/pwr_activity_mon.sv
module pwr_activity_mon
   import pwr_state_pkg::*;
#(
   parameter int          AW         = 16,
   parameter logic [15:0] FIXED_BASE = 16'h0170
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     io_valid,
   input  logic [AW-1:0]            io_addr,
   input  logic [NGRP-1:0][AW-1:0]  grp_base,
   input  logic [NGRP-1:0]          grp_wide,
   input  logic [NSRC-1:0]          src_en,
   output logic                     activity
);

   if (AW < 10 || AW > 16) begin : g_bad_aw
      $error("pwr_activity_mon: AW must lie in 10..16");
   end

   logic [NSRC-1:0] hit;
   logic            act_q;

   // byte-granular compare helper: equal above bit 'lo'
   function automatic logic win(input logic [AW-1:0] a, input logic [AW-1:0] b,
                                input int lo);
      return ((a ^ b) >> lo) == '0;
   endfunction

   assign hit[0] = (io_addr >= AW'(16'h03B0)) && (io_addr <= AW'(16'h03DF));
   assign hit[1] = win(io_addr, AW'(16'h01F0), 3);
   assign hit[2] = win(io_addr, AW'(16'h03F0), 3);
   assign hit[3] = win(io_addr, AW'(16'h03F8), 3) || win(io_addr, AW'(16'h02F8), 3);
   assign hit[4] = (io_addr == AW'(16'h0060)) || (io_addr == AW'(16'h0064));
   assign hit[5] = win(io_addr, AW'(16'h0378), 3);
   assign hit[SRC_FIXED] = win(io_addr, AW'(FIXED_BASE), 3);

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      logic [AW-1:0] keep;
      assign keep = grp_wide[g] ? ~AW'(16'h000F) : ~AW'(16'h0007);
      assign hit[SRC_GRP0 + g] = ((io_addr ^ grp_base[g]) & keep) == '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
      end else begin
         act_q <= io_valid && |(hit & src_en);
      end
   end

   assign activity = act_q;

endmodule

// File: rtl/pwr_state_ctl.sv
module pwr_state_ctl
   import pwr_state_pkg::*;
#(
   parameter int          DW         = 16,
   parameter int          AW         = 16,
   parameter int          TMR_W      = 12,
   parameter int          TICK_DIV   = 1024,
   parameter logic [15:0] FIXED_BASE = 16'h0170
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [3:0]    reg_addr,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   input  logic          io_valid,
   input  logic [AW-1:0] io_addr,
   input  logic          btn_wake,
   input  logic          rtc_alarm,
   input  logic          ac_present,
   input  logic          bat_low,
   input  logic          bat_crit,
   output logic [2:0]    state_pins,
   output logic          backlight_on,
   output logic [1:0]    batt_warn
);

   if (TMR_W > DW || AW > DW || DW < NSRC) begin : g_bad_width
      $error("pwr_state_ctl: TMR_W and AW must fit DW, DW must hold the enable mask");
   end

   logic [TMR_W-1:0]          doze_to, sleep_to, bl_to;
   logic [8:0]                pin_lvl;
   logic [NGRP-1:0][AW-1:0]   grp_base;
   logic [NGRP-1:0]           grp_wide;
   logic [NSRC-1:0]           mon_en;

   pstate_e state_q, state_d;
   logic    bl_on_q;
   logic    tick, act_pulse, wake;
   logic    doze_exp, sleep_exp, bl_exp;

   assign wake = btn_wake | rtc_alarm;

   // ---------------- register port ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         doze_to  <= '0;
         sleep_to <= '0;
         bl_to    <= '0;
         pin_lvl  <= PIN_LVL_RST;
         grp_base <= '0;
         grp_wide <= '0;
         mon_en   <= '1;
      end else if (reg_we) begin
         case (reg_addr)
            RA_DOZE_TO:  doze_to     <= reg_wdata[TMR_W-1:0];
            RA_SLEEP_TO: sleep_to    <= reg_wdata[TMR_W-1:0];
            RA_BL_TO:    bl_to       <= reg_wdata[TMR_W-1:0];
            RA_PIN_LVL:  pin_lvl     <= reg_wdata[8:0];
            RA_GRP_A:    grp_base[0] <= reg_wdata[AW-1:0];
            RA_GRP_B:    grp_base[1] <= reg_wdata[AW-1:0];
            RA_GRP_WIDE: grp_wide    <= reg_wdata[NGRP-1:0];
            RA_MON_EN:   mon_en      <= reg_wdata[NSRC-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      case (reg_addr)
         RA_DOZE_TO:  reg_rdata = DW'(doze_to);
         RA_SLEEP_TO: reg_rdata = DW'(sleep_to);
         RA_BL_TO:    reg_rdata = DW'(bl_to);
         RA_PIN_LVL:  reg_rdata = DW'(pin_lvl);
         RA_GRP_A:    reg_rdata = DW'(grp_base[0]);
         RA_GRP_B:    reg_rdata = DW'(grp_base[1]);
         RA_GRP_WIDE: reg_rdata = DW'(grp_wide);
         RA_MON_EN:   reg_rdata = DW'(mon_en);
         RA_STATUS:   reg_rdata = DW'({bl_on_q, 2'(state_q)});
         default:     reg_rdata = '0;
      endcase
   end

   // ---------------- timebase, monitor, timers ----------------
   pwr_tick_gen #(.DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   pwr_activity_mon #(.AW(AW), .FIXED_BASE(FIXED_BASE)) u_mon (
      .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_addr(io_addr),
      .grp_base(grp_base), .grp_wide(grp_wide), .src_en(mon_en),
      .activity(act_pulse)
   );

   logic restart;
   assign restart = act_pulse | wake | ac_present;

   pwr_idle_timer #(.W(TMR_W)) u_doze_tmr (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .run(state_q == PS_ON), .clr(restart || state_q != PS_ON),
      .limit(doze_to), .expired(doze_exp)
   );

   pwr_idle_timer #(.W(TMR_W)) u_sleep_tmr (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .run(state_q == PS_DOZE), .clr(restart || state_q != PS_DOZE),
      .limit(sleep_to), .expired(sleep_exp)
   );

   pwr_idle_timer #(.W(TMR_W)) u_bl_tmr (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .run(bl_on_q), .clr(restart),
      .limit(bl_to), .expired(bl_exp)
   );

   // ---------------- state ladder ----------------
   always_comb begin
      state_d = state_q;
      if (ac_present) begin
         state_d = PS_ON;
      end else begin
         case (state_q)
            PS_ON:    if (!act_pulse && !wake && doze_exp) state_d = PS_DOZE;
            PS_DOZE:  if (act_pulse || wake)               state_d = PS_ON;
                      else if (sleep_exp)                  state_d = PS_SLEEP;
            PS_SLEEP: if (wake)                            state_d = PS_ON;
            default:                                       state_d = PS_ON;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PS_ON;
         bl_on_q <= 1'b1;
      end else begin
         state_q <= state_d;
         if (restart)     bl_on_q <= 1'b1;
         else if (bl_exp) bl_on_q <= 1'b0;
      end
   end

   // ---------------- outputs ----------------
   always_comb begin
      case (state_q)
         PS_DOZE:  state_pins = pin_lvl[5:3];
         PS_SLEEP: state_pins = pin_lvl[8:6];
         default:  state_pins = pin_lvl[2:0];
      endcase
   end

   assign backlight_on = bl_on_q;
   assign batt_warn    = bat_crit ? 2'b10 : (bat_low ? 2'b01 : 2'b00);

endmodule

// File: rtl/pwr_state_ctl_chk.sv
module pwr_state_ctl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ac_present,
   input logic       wake,
   input logic       act,
   input logic [1:0] st,
   input logic       bl_on
);

   AST_AC_FORCES_ON: assert property (@(posedge clk) disable iff (!rst_n)
      ac_present |=> st == 2'd0);                                    // R9

   AST_SLEEP_DEAF: assert property (@(posedge clk) disable iff (!rst_n)
      (st == 2'd2 && !wake && !ac_present) |=> st == 2'd2);          // R5

   AST_DOZE_ACT_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (st == 2'd1 && act) |=> st == 2'd0);                           // R4

   AST_NO_SKIP_DOZE: assert property (@(posedge clk) disable iff (!rst_n)
      st == 2'd0 |=> st != 2'd2);                                    // R3

   AST_BL_ON_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      act |=> bl_on);                                                // R11

endmodule

bind pwr_state_ctl pwr_state_ctl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .ac_present(ac_present), .wake(wake),
   .act(act_pulse), .st(state_q), .bl_on(bl_on_q)
);

// File: tb/pwr_state_ctl_bench.sv
module pwr_state_ctl_bench;

   localparam int DW = 16;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [3:0]    reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          io_valid = 1'b0;
   logic [AW-1:0] io_addr = '0;
   logic          btn_wake = 1'b0, rtc_alarm = 1'b0, ac_present = 1'b0;
   logic          bat_low = 1'b0, bat_crit = 1'b0;
   logic [2:0]    state_pins;
   logic          backlight_on;
   logic [1:0]    batt_warn;

   int  n_cmp = 0, n_bad = 0;
   bit  done = 0;
   bit  mon_live = 0;
   logic [2:0] exp_q[$];
   string      tag_q[$];

   always #5 clk = ~clk;

   pwr_state_ctl #(.DW(DW), .AW(AW), .TMR_W(8), .TICK_DIV(4)) u_pwr_state_ctl (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .io_valid(io_valid),
      .io_addr(io_addr), .btn_wake(btn_wake), .rtc_alarm(rtc_alarm),
      .ac_present(ac_present), .bat_low(bat_low), .bat_crit(bat_crit),
      .state_pins(state_pins), .backlight_on(backlight_on), .batt_warn(batt_warn)
   );

   task automatic chk(string req, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic chk_range(string req, int act, int lo, int hi);
      n_cmp++;
      if (act < lo || act > hi) begin
         n_bad++;
         $display("FAIL %s: got %0d cycles expected %0d..%0d", req, act, lo, hi);
      end
   endtask

   // driver side of the scoreboard: queue an expected pin vector
   task automatic expect_pins(logic [2:0] v, string req);
      exp_q.push_back(v);
      tag_q.push_back(req);
   endtask

   task automatic wr(logic [3:0] a, int d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = DW'(d);
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(logic [3:0] a, output int d);
      @(negedge clk);
      reg_addr = a;
      #1 d = int'(reg_rdata);
   endtask

   task automatic io_hit(int a);
      @(negedge clk);
      io_valid = 1'b1; io_addr = AW'(a);
      @(negedge clk);
      io_valid = 1'b0;
   endtask

   task automatic pulse_wake(bit rtc);
      @(negedge clk);
      if (rtc) rtc_alarm = 1'b1; else btn_wake = 1'b1;
      @(negedge clk);
      rtc_alarm = 1'b0; btn_wake = 1'b0;
   endtask

   task automatic wait_pins(logic [2:0] v, int limit, string req, output int cyc);
      cyc = 0;
      while (state_pins !== v && cyc < limit) begin
         @(negedge clk);
         cyc++;
      end
      chk(req, int'(state_pins), int'(v));
   endtask

   // wake from DOZE with an access, then watch the ladder return to DOZE
   task automatic wake_by_io(int a, string req);
      int c;
      expect_pins(3'b001, req);
      expect_pins(3'b010, req);
      io_hit(a);
      wait_pins(3'b001, 6, req, c);
      wait_pins(3'b010, 40, req, c);
   endtask

   task automatic no_wake_by_io(int a, string req);
      io_hit(a);
      repeat (10) @(negedge clk);
      chk(req, int'(state_pins), 3'b010);
   endtask

   // monitor side of the scoreboard
   initial begin : monitor
      logic [2:0] prev;
      wait (mon_live);
      prev = state_pins;
      forever begin
         @(negedge clk);
         if (state_pins !== prev) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
               n_bad++;
               $display("FAIL R5/R9: unqueued pin change got %b expected %b", state_pins, prev);
            end else begin
               logic [2:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               if (state_pins !== e) begin
                  n_bad++;
                  $display("FAIL %s: pins got %b expected %b", t, state_pins, e);
               end
            end
            prev = state_pins;
         end
      end
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : stim
      int d, c;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      mon_live = 1;

      // R1 reset state
      chk("R1 pins", int'(state_pins), 3'b001);
      chk("R1 backlight", int'(backlight_on), 1);
      rd(4'd0, d); chk("R1 doze_to", d, 0);
      rd(4'd7, d); chk("R1 enable", d, 'h1FF);
      rd(4'd8, d); chk("R13 status", d, 'h4);

      // R2 zero timeout disables the ladder
      repeat (120) @(negedge clk);
      chk("R2 zero timeout", int'(state_pins), 3'b001);

      // R13 readback truncated to TMR_W
      wr(4'd1, 'hFFFF); rd(4'd1, d); chk("R13 sleep_to width", d, 'hFF);
      wr(4'd1, 0);

      // R12 battery code
      bat_low = 1'b1; #1 chk("R12 low", int'(batt_warn), 1);
      bat_crit = 1'b1; #1 chk("R12 both", int'(batt_warn), 2);
      bat_low = 1'b0; #1 chk("R12 crit", int'(batt_warn), 2);
      bat_crit = 1'b0; #1 chk("R12 none", int'(batt_warn), 0);

      // R10 pin levels
      expect_pins(3'b110, "R10");
      wr(4'd3, 'h116);
      @(negedge clk); chk("R10 on level", int'(state_pins), 3'b110);
      expect_pins(3'b001, "R10");
      wr(4'd3, 'h111);

      // R11 backlight timer
      wr(4'd2, 4);
      io_hit('h1F2);
      repeat (2) @(negedge clk); chk("R11 lit after access", int'(backlight_on), 1);
      repeat (40) @(negedge clk); chk("R11 off after idle", int'(backlight_on), 0);
      io_hit('h060);
      repeat (2) @(negedge clk); chk("R11 relit", int'(backlight_on), 1);
      wr(4'd2, 0);

      // R2 / R3 ladder timing
      wr(4'd1, 3);
      expect_pins(3'b010, "R2");
      expect_pins(3'b100, "R3");
      wr(4'd0, 5);
      io_hit('h1F0);
      wait_pins(3'b010, 40, "R2 enter doze", c);
      chk_range("R2 doze delay", c, 16, 26);
      wait_pins(3'b100, 40, "R3 enter sleep", c);
      chk_range("R3 sleep delay", c, 8, 16);
      rd(4'd8, d); chk("R13 status sleep", d & 3, 2);

      // R5 sleep ignores access, button wakes
      io_hit('h1F0);
      io_hit('h3C0);
      repeat (30) @(negedge clk);
      chk("R5 sleep ignores io", int'(state_pins), 3'b100);
      wr(4'd1, 0);
      expect_pins(3'b001, "R5 button");
      expect_pins(3'b010, "R2 redoze");
      pulse_wake(0);
      wait_pins(3'b001, 4, "R5 button wake", c);
      wait_pins(3'b010, 40, "R2 redoze", c);

      // R4 / R6 device windows from DOZE
      wake_by_io('h3B0, "R6 display");
      wake_by_io('h3DF, "R6 display top");
      wake_by_io('h3F2, "R6 diskette");
      wake_by_io('h2FA, "R6 serial");
      wake_by_io('h064, "R6 keyboard");
      wake_by_io('h37A, "R4 printer");
      no_wake_by_io('h3E0, "R6 outside display");
      wr(4'd7, 'h1FD);
      no_wake_by_io('h1F3, "R6 disabled disk");

      // R7 programmable windows
      wr(4'd4, 'h300);
      wr(4'd5, 'h340);
      wr(4'd7, 'h180);
      wake_by_io('h305, "R7 window A");
      no_wake_by_io('h309, "R7 narrow A");
      wr(4'd6, 1);
      wake_by_io('h30A, "R7 wide A");
      wake_by_io('h347, "R7 window B");
      no_wake_by_io('h348, "R7 narrow B");

      // R8 fixed window
      wr(4'd7, 'h040);
      wake_by_io('h172, "R8 fixed");
      no_wake_by_io('h178, "R8 outside fixed");
      wr(4'd7, 'h1FF);

      // R5 RTC wake from DOZE
      expect_pins(3'b001, "R5 rtc");
      expect_pins(3'b010, "R5 redoze");
      pulse_wake(1);
      wait_pins(3'b001, 4, "R5 rtc wake", c);
      wait_pins(3'b010, 40, "R5 redoze", c);

      // R9 wall power
      expect_pins(3'b100, "R3");
      wr(4'd1, 3);
      wait_pins(3'b100, 40, "R3 sleep again", c);
      expect_pins(3'b001, "R9");
      @(negedge clk); ac_present = 1'b1;
      wait_pins(3'b001, 3, "R9 forced on", c);
      repeat (150) @(negedge clk);
      chk("R9 held on", int'(state_pins), 3'b001);
      chk("R9 backlight", int'(backlight_on), 1);
      expect_pins(3'b010, "R9 release");
      expect_pins(3'b100, "R9 release");
      ac_present = 1'b0;
      wait_pins(3'b100, 60, "R9 ladder resumes", c);

      repeat (5) @(negedge clk);
      chk("R4 scoreboard drained", exp_q.size(), 0);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule